// File: doc/BRIEF.md
# TDM Backplane Frame Timing and Strobe Generator

This block derives all frame-level timing for a 2.048 Mbit/s time-division backplane from a 4.096 MHz master clock and an active-low frame pulse. It tracks the bit position within the 125 µs frame with a counter of master-clock cycles. The counter restarts on every frame pulse. From that position the block produces a half-rate bit clock, two channel strobes and a delayed, active-low frame pulse. Three-state pins are modelled as a data output plus an output enable.

The block also works out how the frame pulse input is being used. A short low pulse every frame selects backplane mode, in which the generated timing is driven out. A frame input held low selects the strobe-driven serial mode, in which other pins take over the timing and every generated output is released. A linear-PCM input widens the data fields to 16 bits. It reshapes strobe 1 into a single end-of-frame bit, turns strobe 2 off and moves the delayed frame pulse later.

Top module: `tdm_frame_timing`

## Requirements
- R1: After reset every output enable is low, `bclk_o` and both strobes are low, `dfp_n_o` is high and `bus_mode_o` is low. This holds until a valid frame pulse is seen. A valid frame pulse is `frame_n` sampled low on one or two consecutive edges and then sampled high.
- R2: Once running, the frame position k is 0 in the cycle after the last low sample of `frame_n`. k then advances by one each cycle, wrapping from 511 to 0. `bclk_o` equals bit 0 of k, so it is low in the first master cycle of each bit period and high in the second.
- R3: With `linear_i`=0, `dfp_n_o` is low for exactly one cycle, at k=63. That is 64 master cycles after the cycle in which `frame_n` was low.
- R4: With `linear_i`=1, `dfp_n_o` is low for one cycle at k=127, which is 128 cycles after the frame pulse.
- R5: With `linear_i`=0, `stb1_o` is high for bit periods 8 to 15 (k=16..31) and `stb2_o` is high for bit periods 16 to 23 (k=32..47). A bit period is k divided by 2.
- R6: With `linear_i`=1, `stb1_o` is high only in bit period 255 (k=510..511). `stb2_o` and `stb2_oe` are low.
- R7: If `frame_n` is sampled low on more than 2 consecutive edges, the block enters serial mode. In serial mode `bclk_o` holds low, every output enable drops and `bus_mode_o` goes low. If `frame_n` stays high, `bclk_o` keeps toggling.
- R8: If a frame ends (k=511 with `frame_n` high) without a pulse, the strobes stay low and `dfp_n_o` stays high until the next valid pulse. The bit clock keeps running throughout.
- R9: `pwr_n` low deasserts every output enable at once, without waiting for a clock edge. After it is released, outputs restart only on a new valid frame pulse.
- R10: A frame pulse two cycles wide is valid. The frame timing is taken from its last low sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock (4.096 MHz nominal) |
| pwr_n | input | 1 | Asynchronous active-low power-down; release is synchronised internally |
| frame_n | input | 1 | Active-low frame pulse, or held low to select serial mode |
| linear_i | input | 1 | 1 selects 16-bit linear PCM timing, 0 selects 8-bit timing |
| bus_mode_o | output | 1 | High while backplane mode is active |
| bclk_o | output | 1 | Half-rate bit clock |
| bclk_oe | output | 1 | Output enable of the bit clock |
| stb1_o | output | 1 | Channel strobe 1 |
| stb1_oe | output | 1 | Output enable of strobe 1 |
| stb2_o | output | 1 | Channel strobe 2 |
| stb2_oe | output | 1 | Output enable of strobe 2 |
| dfp_n_o | output | 1 | Delayed frame pulse, active low |
| dfp_oe | output | 1 | Output enable of the delayed frame pulse |

## Verification
The bench sweeps every cycle of several whole frames and compares all outputs against a frame-position model of its own. It covers both PCM widths and a width change on the fly.

- A block that counted from the first low sample of a two-cycle pulse would place the delayed pulse one cycle early.
- A block that treated a three-cycle low as a pulse would keep driving a clock into serial mode.
- After a missing frame pulse, a wrong design would either keep pulsing the strobes from a free-running counter or stop the bit clock as well.
- A power-down that waited for a clock edge would leave the outputs enabled mid-cycle.
- A restart that skipped the frame-pulse qualification would drive outputs before any pulse arrived.

// File: rtl/tdm_timing_pkg.sv
package tdm_timing_pkg;

  // Frame-lock state shared between the tracker and the output decode.
  typedef struct packed {
    logic started;   // backplane mode active, outputs driven
    logic frame_ok;  // a pulse was seen at every frame boundary since start
  } tdm_lock_t;

  localparam tdm_lock_t LOCK_IDLE = '{started: 1'b0, frame_ok: 1'b0};

endpackage

// File: rtl/tdm_rst_sync.sv
module tdm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/tdm_frame_track.sv
module tdm_frame_track
  import tdm_timing_pkg::*;
#(
  parameter int CNT_W     = 9,
  parameter int LOW_LIMIT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_n,
  output logic [CNT_W-1:0] cnt_o,
  output tdm_lock_t        lock_o
);

  localparam int              LOW_W     = $clog2(LOW_LIMIT + 2);
  localparam logic [LOW_W-1:0] LOW_SAT  = LOW_W'(LOW_LIMIT + 1);
  localparam logic [CNT_W-1:0] FRAME_END = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [LOW_W-1:0] low_q, low_d;
  tdm_lock_t        lock_q, lock_d;
  logic             pulse_done;

  // A high sample that ends a low run of 1..LOW_LIMIT samples qualifies a pulse.
  assign pulse_done = frame_n && (low_q != '0) && (low_q != LOW_SAT);

  always_comb begin
    cnt_d  = cnt_q;
    low_d  = low_q;
    lock_d = lock_q;
    if (!frame_n) begin
      cnt_d = '0;
      if (low_q != LOW_SAT) low_d = low_q + LOW_W'(1);
      if (low_d == LOW_SAT) lock_d = LOCK_IDLE;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
      low_d = '0;
      if (pulse_done) begin
        lock_d.started  = 1'b1;
        lock_d.frame_ok = 1'b1;
      end else if (cnt_q == FRAME_END) begin
        lock_d.frame_ok = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      low_q  <= '0;
      lock_q <= LOCK_IDLE;
    end else begin
      cnt_q  <= cnt_d;
      low_q  <= low_d;
      lock_q <= lock_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign lock_o = lock_q;

  a_r8_ok_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q.frame_ok |-> lock_q.started);

  a_r7_long_low_idles: assert property (@(posedge clk) disable iff (!rst_n)
    (low_q == LOW_SAT) |-> !lock_q.started);

  a_r10_start_position: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q.started) |-> (cnt_q == CNT_W'(1)));

endmodule

// File: rtl/tdm_strobe_gen.sv
module tdm_strobe_gen
  import tdm_timing_pkg::*;
#(
  parameter int CNT_W      = 9,
  parameter int SLOT_BITS  = 8,
  parameter int STB1_SLOT  = 1,
  parameter int STB2_SLOT  = 2,
  parameter int DLY_NARROW = 64,
  parameter int DLY_WIDE   = 128
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  tdm_lock_t        lock_i,
  input  logic             linear_i,
  output logic             bclk_o,
  output logic             bclk_oe,
  output logic             stb1_o,
  output logic             stb1_oe,
  output logic             stb2_o,
  output logic             stb2_oe,
  output logic             dfp_n_o,
  output logic             dfp_oe
);

  localparam int               BIT_W    = CNT_W - 1;
  localparam logic [CNT_W-1:0] HIT_NARR = CNT_W'(DLY_NARROW - 1);
  localparam logic [CNT_W-1:0] HIT_WIDE = CNT_W'(DLY_WIDE - 1);

  logic [BIT_W-1:0] bit_idx;
  logic [1:0]       in_slot;
  logic             last_bit;
  logic             dly_hit;

  assign bit_idx  = cnt_i[CNT_W-1:1];
  assign last_bit = &bit_idx;

  for (genvar g = 0; g < 2; g++) begin : g_slot
    localparam int               SLOT = (g == 0) ? STB1_SLOT : STB2_SLOT;
    localparam logic [BIT_W-1:0] FIRST = BIT_W'(SLOT * SLOT_BITS);
    localparam logic [BIT_W-1:0] LAST  = BIT_W'(SLOT * SLOT_BITS + SLOT_BITS - 1);
    assign in_slot[g] = (bit_idx >= FIRST) && (bit_idx <= LAST);
  end

  always_comb begin
    dly_hit = linear_i ? (cnt_i == HIT_WIDE) : (cnt_i == HIT_NARR);
    bclk_o  = lock_i.started & cnt_i[0];
    stb1_o  = lock_i.frame_ok & (linear_i ? last_bit : in_slot[0]);
    stb2_o  = lock_i.frame_ok & ~linear_i & in_slot[1];
    dfp_n_o = ~(lock_i.frame_ok & dly_hit);
    bclk_oe = lock_i.started;
    stb1_oe = lock_i.started;
    stb2_oe = lock_i.started & ~linear_i;
    dfp_oe  = lock_i.started;
  end

  a_r5_strobes_disjoint: assert final ($onehot0({stb1_o, stb2_o}));

endmodule

// File: rtl/tdm_frame_timing.sv
module tdm_frame_timing
  import tdm_timing_pkg::*;
#(
  parameter int FRAME_BITS = 256,
  parameter int SLOT_BITS  = 8,
  parameter int STB1_SLOT  = 1,
  parameter int STB2_SLOT  = 2,
  parameter int DLY_NARROW = 64,
  parameter int DLY_WIDE   = 128,
  parameter int LOW_LIMIT  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic pwr_n,
  input  logic frame_n,
  input  logic linear_i,
  output logic bus_mode_o,
  output logic bclk_o,
  output logic bclk_oe,
  output logic stb1_o,
  output logic stb1_oe,
  output logic stb2_o,
  output logic stb2_oe,
  output logic dfp_n_o,
  output logic dfp_oe
);

  localparam int FRAME_CLKS = FRAME_BITS * 2;
  localparam int CNT_W      = $clog2(FRAME_CLKS);

  logic             rst_n;
  logic [CNT_W-1:0] cnt;
  tdm_lock_t        lock;

  tdm_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .arst_n  (pwr_n),
    .rst_n_o (rst_n)
  );

  tdm_frame_track #(.CNT_W(CNT_W), .LOW_LIMIT(LOW_LIMIT)) u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .frame_n (frame_n),
    .cnt_o   (cnt),
    .lock_o  (lock)
  );

  tdm_strobe_gen #(
    .CNT_W      (CNT_W),
    .SLOT_BITS  (SLOT_BITS),
    .STB1_SLOT  (STB1_SLOT),
    .STB2_SLOT  (STB2_SLOT),
    .DLY_NARROW (DLY_NARROW),
    .DLY_WIDE   (DLY_WIDE)
  ) u_stb (
    .cnt_i    (cnt),
    .lock_i   (lock),
    .linear_i (linear_i),
    .bclk_o   (bclk_o),
    .bclk_oe  (bclk_oe),
    .stb1_o   (stb1_o),
    .stb1_oe  (stb1_oe),
    .stb2_o   (stb2_o),
    .stb2_oe  (stb2_oe),
    .dfp_n_o  (dfp_n_o),
    .dfp_oe   (dfp_oe)
  );

  assign bus_mode_o = lock.started;

  a_r2_bclk_half_rate: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_o |=> !bclk_o);

  a_r3_dfp_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    !dfp_n_o |=> dfp_n_o);

endmodule

// File: tb/sim_tdm_frame_timing.sv
module sim_tdm_frame_timing;

  logic clk = 1'b0;
  logic pwr_n, frame_n, linear_i;
  logic bus_mode_o, bclk_o, bclk_oe, stb1_o, stb1_oe, stb2_o, stb2_oe, dfp_n_o, dfp_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Bench frame model, built from the requirement text.
  int  m_k = 0;
  int  m_low = 0;
  bit  m_started = 1'b0;
  bit  m_ok = 1'b0;

  always #5 clk = ~clk;

  tdm_frame_timing u0 (
    .clk(clk), .pwr_n(pwr_n), .frame_n(frame_n), .linear_i(linear_i),
    .bus_mode_o(bus_mode_o), .bclk_o(bclk_o), .bclk_oe(bclk_oe),
    .stb1_o(stb1_o), .stb1_oe(stb1_oe), .stb2_o(stb2_o), .stb2_oe(stb2_oe),
    .dfp_n_o(dfp_n_o), .dfp_oe(dfp_oe)
  );

  task automatic chk(input bit cond, input string tag, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (k=%0d, t=%0t)", tag, act, exp, m_k, $time);
    end
  endtask

  // Model update at a rising edge for the frame_n value that edge sampled.
  task automatic model_edge(input logic fn);
    if (!fn) begin
      m_k = 0;
      if (m_low < 3) m_low++;
      if (m_low == 3) begin m_started = 1'b0; m_ok = 1'b0; end   // R7
    end else begin
      if (m_low == 1 || m_low == 2) begin m_started = 1'b1; m_ok = 1'b1; end
      else if (m_k == 511) m_ok = 1'b0;                          // R8
      m_k = (m_k + 1) % 512;
      m_low = 0;
    end
  endtask

  task automatic compare_all();
    int  b;
    bit  e_s1, e_s2, e_dfp;
    b = m_k / 2;
    if (linear_i) begin
      e_s1 = m_ok && (b == 255);
      e_s2 = 1'b0;
      e_dfp = !(m_ok && m_k == 127);
    end else begin
      e_s1 = m_ok && (b >= 8) && (b <= 15);
      e_s2 = m_ok && (b >= 16) && (b <= 23);
      e_dfp = !(m_ok && m_k == 63);
    end
    chk(bclk_o == (m_started && m_k[0]), "R2 bclk_o", bclk_o, m_started && m_k[0]);
    chk(bclk_oe == m_started, "R7 bclk_oe", bclk_oe, m_started);
    chk(bus_mode_o == m_started, "R7 bus_mode_o", bus_mode_o, m_started);
    chk(stb1_oe == m_started, "R1 stb1_oe", stb1_oe, m_started);
    chk(dfp_oe == m_started, "R1 dfp_oe", dfp_oe, m_started);
    chk(stb2_oe == (m_started && !linear_i), "R6 stb2_oe", stb2_oe, m_started && !linear_i);
    chk(stb1_o == e_s1, linear_i ? "R6 stb1_o" : "R5 stb1_o", stb1_o, e_s1);
    chk(stb2_o == e_s2, linear_i ? "R6 stb2_o" : "R5 stb2_o", stb2_o, e_s2);
    chk(dfp_n_o == e_dfp, linear_i ? "R4 dfp_n_o" : "R3 dfp_n_o", dfp_n_o, e_dfp);
  endtask

  // Drive frame_n for one cycle, step the model at the edge, check mid-low phase.
  task automatic tick(input logic fn);
    frame_n = fn;
    @(posedge clk);
    model_edge(fn);
    @(negedge clk);
    compare_all();
  endtask

  task automatic run_frame(input int pulse_w, input int len);
    for (int i = 0; i < pulse_w; i++) tick(1'b0);
    for (int i = pulse_w; i < len; i++) tick(1'b1);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    pwr_n = 1'b0; frame_n = 1'b1; linear_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(!bclk_oe && !stb1_oe && !stb2_oe && !dfp_oe, "R1 oe in reset",
        {bclk_oe, stb1_oe, stb2_oe, dfp_oe}, 0);
    pwr_n = 1'b1;
    for (int i = 0; i < 20; i++) tick(1'b1);          // R1: no pulse, stay idle
    chk(!bus_mode_o && !bclk_oe, "R1 idle before pulse", bus_mode_o, 0);

    // Narrow mode, single-cycle pulses, three whole frames.
    for (int f = 0; f < 3; f++) run_frame(1, 512);

    // Width change on the fly, then linear frames.
    linear_i = 1'b1;
    for (int f = 0; f < 2; f++) run_frame(1, 512);
    linear_i = 1'b0;

    // R10: two-cycle pulse; timing follows the last low sample.
    run_frame(2, 513);
    tick(1'b0);
    for (int i = 0; i < 63; i++) tick(1'b1);
    chk(dfp_n_o == 1'b0, "R10 dfp after 2-cycle pulse", dfp_n_o, 0);
    for (int i = 64; i < 512; i++) tick(1'b1);

    // R8: missing pulse; strobes and dfp quiet, bclk keeps running.
    tick(1'b0);
    for (int i = 1; i < 1100; i++) tick(1'b1);
    chk(bclk_oe == 1'b1 && m_ok == 1'b0, "R8 clock runs after missed pulse", bclk_oe, 1);

    // Recovery, then an early (short) frame.
    run_frame(1, 300);
    run_frame(1, 512);

    // R7: low for 3 cycles selects serial mode.
    for (int i = 0; i < 5; i++) tick(1'b0);
    chk(!bus_mode_o && !bclk_o && !bclk_oe, "R7 serial mode", bus_mode_o, 0);
    for (int i = 0; i < 40; i++) tick(1'b1);
    chk(!bclk_oe, "R7 stays idle without pulse", bclk_oe, 0);

    // Restart, then power-down in the middle of a cycle.
    run_frame(1, 200);
    #2 pwr_n = 1'b0;
    #1;
    chk(!bclk_oe && !stb1_oe && !stb2_oe && !dfp_oe, "R9 async power-down",
        {bclk_oe, stb1_oe, stb2_oe, dfp_oe}, 0);
    m_started = 1'b0; m_ok = 1'b0; m_low = 0;
    @(negedge clk);
    pwr_n = 1'b1;
    for (int i = 0; i < 30; i++) tick(1'b1);
    chk(!bus_mode_o, "R9 idle after release", bus_mode_o, 0);
    run_frame(1, 512);
    linear_i = 1'b1;
    run_frame(1, 512);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule